// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog for a processor subsystem. A 6-bit down-counter, driven by a programmable power-of-two prescaler, measures how long software has gone without servicing it. Software services it by writing a fixed 32-bit key to a reload register, and that write only counts if the counter has already fallen into a window: at or below a programmed compare value. A key written too early is treated as a fault, and so is letting the counter run down to zero. Either fault raises a one-cycle system reset request and sets a sticky reset flag. The flag lives on a separate power-on reset, so software can see after the restart why the restart happened.

When the counter reaches the window compare value it also sets an interrupt flag. That flag, together with an enable bit, drives a level interrupt, so software gets a warning that the service window has opened. A debug-halt input can freeze counting unless a control bit tells the block to keep running while the system is halted.

The core is a three-state machine:
- **OFF**: the counter is idle and holds its value.
- **ARMED**: the counter is counting.
- **BITE**: the reset request is being issued.

The transitions are:
- **start**: OFF to ARMED when the enable bit is seen set. It loads 0x3F and clears the prescaler.
- **service**: ARMED to ARMED on a legal key write. It reloads 0x3F and clears the prescaler.
- **early_fault**: ARMED to BITE on a key write while the count is above the window.
- **expire**: ARMED to BITE when a decrement reaches 0.
- **stop**: ARMED to OFF when the enable bit is cleared.
- **rearm**: BITE to ARMED when enabled. It reloads 0x3F.
- **halt**: BITE to OFF when not enabled.

Top module: `wwdog_top`

## Requirements
- R1: After reset every register reads zero and both outputs are low. The register map is:
  - 0x00: reload, write-only, reads 0.
  - 0x04: control.
  - 0x08: interrupt enable, bit 0.
  - 0x0C: status. Bit 0 is the interrupt flag and bit 1 is the reset flag.
  - 0x10: live count in bits 5:0.
- R2: When control bit 0 is seen set while the block is OFF, the count becomes 0x3F on the next clock and the prescaler restarts.
- R3: With control bits 11:8 equal to N, the count decrements by exactly one every 2^N clocks while counting.
- R4: A decrement that reaches 0 gives a sys_rst_req pulse exactly one clock wide and sets status bit 1.
- R5: Writing 0x00005AA5 to offset 0x00 while the count is at or below the window value (control bits 21:16) sets the count to 0x3F without a reset request.
- R6: Writing the key while the count is above the window value gives a one-clock reset request, sets status bit 1, and the count restarts from 0x3F.
- R7: Any other value written to offset 0x00 leaves the count and the outputs unaffected.
- R8: Status bit 0 is set by the decrement that lands on the window value. irq is high exactly when status bit 0 and interrupt enable bit 0 are both 1.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: While dbg_halt is high and control bit 31 is 0, the count holds. With control bit 31 set to 1, it keeps counting.
- R11: The reset flag survives rst_n and is cleared only by flag_por_n or by a write of 1 to it.
- R12: Clearing control bit 0 stops counting and the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset for everything except the reset flag |
| flag_por_n | input | 1 | Active-low power-on reset for the reset flag |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dbg_halt | input | 1 | System debug-halt indication |
| irq | output | 1 | Level interrupt |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench sweeps the prescale select over several values and measures the spacing between decrements. An off-by-one in the prescaler mask would show up as a period of 2^N+1 or 2^(N-1).

It services the watchdog both just inside the window and right after a start. A design that compares the window with the wrong inequality would reset on a legal service or accept an early one.

It checks that the reset pulse is exactly one cycle and that the count restarts afterwards. A machine that lingered in BITE, or left the count at 0, would fire repeatedly.

It also checks that the reset flag persists across rst_n, that W1C writes of zero leave flags alone, and that a near-miss key is ignored.

// File: rtl/wwdog_pkg.sv
package wwdog_pkg;

    localparam logic [31:0] SERVICE_KEY = 32'h0000_5AA5;

    localparam logic [4:0] OFS_RELOAD = 5'h00;
    localparam logic [4:0] OFS_CTRL   = 5'h04;
    localparam logic [4:0] OFS_IE     = 5'h08;
    localparam logic [4:0] OFS_STAT   = 5'h0C;
    localparam logic [4:0] OFS_COUNT  = 5'h10;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SEL_LSB  = 8;
    localparam int CTRL_WIN_LSB  = 16;
    localparam int CTRL_DRUN_BIT = 31;

    localparam int STAT_IF_BIT = 0;
    localparam int STAT_RF_BIT = 1;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_BITE  = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wwdog_prescale.sv
module wwdog_prescale #(
    parameter int SEL_W = 4,
    parameter int PS_W  = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PS_W-1:0] pre_q;
    logic [PS_W-1:0] mask;

    // low sel bits all ones marks the end of a 2^sel period
    assign mask = (PS_W'(1) << sel) - PS_W'(1);
    assign tick = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + PS_W'(1);
        end
    end
endmodule

// File: rtl/wwdog_regs.sv
module wwdog_regs
    import wwdog_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 6,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              set_if,
    input  logic              set_rf,
    output logic              en,
    output logic [SEL_W-1:0]  psel,
    output logic [CNT_W-1:0]  win,
    output logic              dbg_run,
    output logic              ie,
    output logic              if_flag,
    output logic              rf_flag,
    output logic              key_wr
);
    logic wr_ctrl, wr_ie, wr_stat;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_ie   = bus_wr && (bus_addr == ADDR_W'(OFS_IE));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign key_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_RELOAD))
                     && (bus_wdata == SERVICE_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en      <= 1'b0;
            psel    <= '0;
            win     <= '0;
            dbg_run <= 1'b0;
            ie      <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en      <= bus_wdata[CTRL_EN_BIT];
                psel    <= bus_wdata[CTRL_SEL_LSB +: SEL_W];
                win     <= bus_wdata[CTRL_WIN_LSB +: CNT_W];
                dbg_run <= bus_wdata[CTRL_DRUN_BIT];
            end
            if (wr_ie) begin
                ie <= bus_wdata[0];
            end
        end
    end

    // interrupt flag: set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            if_flag <= 1'b0;
        end else if (set_if) begin
            if_flag <= 1'b1;
        end else if (wr_stat && bus_wdata[STAT_IF_BIT]) begin
            if_flag <= 1'b0;
        end
    end

    // reset flag: on the power-on domain only
    always_ff @(posedge clk or negedge flag_por_n) begin
        if (!flag_por_n) begin
            rf_flag <= 1'b0;
        end else if (set_rf) begin
            rf_flag <= 1'b1;
        end else if (wr_stat && bus_wdata[STAT_RF_BIT]) begin
            rf_flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_CTRL): begin
                bus_rdata[CTRL_EN_BIT]               = en;
                bus_rdata[CTRL_SEL_LSB +: SEL_W]     = psel;
                bus_rdata[CTRL_WIN_LSB +: CNT_W]     = win;
                bus_rdata[CTRL_DRUN_BIT]             = dbg_run;
            end
            ADDR_W'(OFS_IE):    bus_rdata[0] = ie;
            ADDR_W'(OFS_STAT): begin
                bus_rdata[STAT_IF_BIT] = if_flag;
                bus_rdata[STAT_RF_BIT] = rf_flag;
            end
            ADDR_W'(OFS_COUNT): bus_rdata[CNT_W-1:0] = cnt;
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wwdog_fsm.sv
module wwdog_fsm
    import wwdog_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             key_wr,
    input  logic [CNT_W-1:0] win,
    output logic [CNT_W-1:0] cnt,
    output wd_state_e        state,
    output logic             pre_clr,
    output logic             set_if,
    output logic             set_rf,
    output logic             bite
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    wd_state_e        st_n;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] cnt_dec;

    assign cnt_dec = cnt - CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_OFF;
            cnt   <= '0;
        end else begin
            state <= st_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        st_n    = state;
        cnt_n   = cnt;
        pre_clr = 1'b0;
        set_if  = 1'b0;
        set_rf  = 1'b0;
        unique case (state)
            WD_OFF: begin
                if (en) begin                       // start
                    st_n    = WD_ARMED;
                    cnt_n   = CNT_TOP;
                    pre_clr = 1'b1;
                end
            end
            WD_ARMED: begin
                if (!en) begin                      // stop
                    st_n = WD_OFF;
                end else if (key_wr) begin
                    if (cnt <= win) begin           // service
                        cnt_n   = CNT_TOP;
                        pre_clr = 1'b1;
                    end else begin                  // early_fault
                        st_n   = WD_BITE;
                        set_rf = 1'b1;
                    end
                end else if (tick) begin
                    cnt_n = cnt_dec;
                    if (cnt_dec == win) begin
                        set_if = 1'b1;
                    end
                    if (cnt_dec == '0) begin        // expire
                        st_n   = WD_BITE;
                        set_rf = 1'b1;
                    end
                end
            end
            WD_BITE: begin                          // rearm / halt
                cnt_n   = CNT_TOP;
                pre_clr = 1'b1;
                st_n    = en ? WD_ARMED : WD_OFF;
            end
            default: begin
                st_n = WD_OFF;
            end
        endcase
    end

    always_comb begin
        bite = (state == WD_BITE);
    end
endmodule

// File: rtl/wwdog_top.sv
module wwdog_top
    import wwdog_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 6,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dbg_halt,
    output logic              irq,
    output logic              sys_rst_req
);
    localparam int PS_W = (1 << SEL_W) - 1;

    logic             en, dbg_run, ie, if_flag, rf_flag, key_wr;
    logic [SEL_W-1:0] psel;
    logic [CNT_W-1:0] win, cnt_q;
    logic             tick, pre_clr, set_if, set_rf, armed, run;
    wd_state_e        state;

    wwdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .flag_por_n(flag_por_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt(cnt_q), .set_if(set_if), .set_rf(set_rf),
        .en(en), .psel(psel), .win(win), .dbg_run(dbg_run), .ie(ie),
        .if_flag(if_flag), .rf_flag(rf_flag), .key_wr(key_wr)
    );

    assign armed = (state == WD_ARMED);
    assign run   = armed && (!dbg_halt || dbg_run);

    wwdog_prescale #(.SEL_W(SEL_W), .PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .run(run),
        .sel(psel), .tick(tick)
    );

    wwdog_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .key_wr(key_wr),
        .win(win), .cnt(cnt_q), .state(state), .pre_clr(pre_clr),
        .set_if(set_if), .set_rf(set_rf), .bite(sys_rst_req)
    );

    assign irq = if_flag && ie;
endmodule

// File: rtl/wwdog_chk.sv
module wwdog_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flag_por_n,
    input logic             armed,
    input logic             en,
    input logic             key_wr,
    input logic             dbg_halt,
    input logic             dbg_run,
    input logic [CNT_W-1:0] win,
    input logic [CNT_W-1:0] cnt_q,
    input logic             rf_flag,
    input logic             sys_rst_req
);
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    p_flag_with_pulse_r6: assert property (@(posedge clk)
        disable iff (!rst_n || !flag_por_n)
        sys_rst_req |-> rf_flag);

    p_service_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && en && key_wr && (cnt_q <= win)) |=> (cnt_q == '1));

    p_no_zero_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cnt_q != '0));

    p_debug_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && en && dbg_halt && !dbg_run && !key_wr) |=> $stable(cnt_q));

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed)) |->
        ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - CNT_W'(1))
         || (cnt_q == '1)));
endmodule

bind wwdog_top wwdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flag_por_n(flag_por_n), .armed(armed),
    .en(en), .key_wr(key_wr), .dbg_halt(dbg_halt), .dbg_run(dbg_run),
    .win(win), .cnt_q(cnt_q), .rf_flag(rf_flag), .sys_rst_req(sys_rst_req)
);

// File: tb/wwdog_top_test.sv
`timescale 1ns/1ps
module wwdog_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_por_n = 1'b0;
    logic [4:0]  bus_addr = 5'h10;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        irq, sys_rst_req;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rst_cnt = 0;

    localparam logic [31:0] KEY = 32'h0000_5AA5;

    wwdog_top uut (
        .clk(clk), .rst_n(rst_n), .flag_por_n(flag_por_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dbg_halt(dbg_halt), .irq(irq),
        .sys_rst_req(sys_rst_req)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (sys_rst_req) rst_cnt <= rst_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 5'h10;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 5'h10;
    endtask

    function automatic logic [31:0] ctrl(input bit en, input int n, input int w, input bit drun);
        return {drun, 9'd0, w[5:0], 4'd0, n[3:0], 7'd0, en};
    endfunction

    task automatic wait_cnt(input logic [5:0] v);
        logic [31:0] d;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            rd(5'h10, d);
            if (d[5:0] == v) return;
        end
        chk("wait_cnt timeout", 32'd1, 32'd0);
    endtask

    task automatic next_change(output int at);
        logic [31:0] d0, d;
        rd(5'h10, d0);
        at = -1;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            rd(5'h10, d);
            if (d != d0) begin at = cyc; return; end
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int t0, t1, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; flag_por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, d); chk("R1 reload reads", d, 0);
        rd(5'h04, d); chk("R1 ctrl", d, 0);
        rd(5'h08, d); chk("R1 ie", d, 0);
        rd(5'h0C, d); chk("R1 status", d, 0);
        rd(5'h10, d); chk("R1 count", d, 0);
        chk("R1 outputs", {irq, sys_rst_req}, 0);

        // R2 start loads 0x3F
        wr(5'h04, ctrl(1, 4, 0, 0));
        rd(5'h04, d); chk("R1 ctrl readback", d, ctrl(1, 4, 0, 0));
        @(negedge clk);
        rd(5'h10, d); chk("R2 start load", d, 32'h3F);

        // R3 prescale sweep
        for (int n = 0; n < 6; n++) begin
            wr(5'h04, 0);
            wr(5'h04, ctrl(1, n, 0, 0));
            next_change(t0);
            next_change(t1);
            chk($sformatf("R3 period N=%0d", n), t1 - t0, 1 << n);
        end

        // R12 disable holds count
        wr(5'h04, 0);
        rd(5'h10, d);
        repeat (10) @(negedge clk);
        begin
            logic [31:0] d2;
            rd(5'h10, d2); chk("R12 hold when off", d2, d);
        end

        // R6 early key
        wr(5'h04, ctrl(1, 0, 6'h10, 0));
        r0 = rst_cnt;
        wr(5'h00, KEY);
        chk("R6 reset pulse now", sys_rst_req, 1);
        @(negedge clk);
        chk("R6 one pulse", rst_cnt - r0, 1);
        rd(5'h0C, d); chk("R6 reset flag", d[1], 1);
        rd(5'h10, d); chk("R6 restart", d, 32'h3F);

        // R9 write zero keeps, write one clears
        wr(5'h0C, 0);
        rd(5'h0C, d); chk("R9 zero write keeps", d[1], 1);
        wr(5'h0C, 32'h2);
        rd(5'h0C, d); chk("R9 rf cleared", d[1], 0);

        // R7 wrong key ignored
        r0 = rst_cnt;
        wr(5'h00, 32'h0000_5AA4);
        wr(5'h00, 32'h0001_5AA5);
        rd(5'h10, d);
        chk("R7 no reset", rst_cnt - r0, 0);
        chk("R7 still counting", d < 32'h3C ? 1 : 0, 1);

        // R5 legal service at window, R8 flag
        wait_cnt(6'h10);
        rd(5'h0C, d); chk("R8 if set at window", d[0], 1);
        chk("R8 irq gated", irq, 0);
        r0 = rst_cnt;
        wr(5'h00, KEY);
        rd(5'h10, d); chk("R5 reload", d, 32'h3F);
        chk("R5 no reset", rst_cnt - r0, 0);
        wr(5'h08, 1);
        chk("R8 irq on", irq, 1);
        wr(5'h0C, 0);
        chk("R9 if kept", irq, 1);
        wr(5'h0C, 1);
        rd(5'h0C, d); chk("R9 if cleared", d[0], 0);
        chk("R8 irq off", irq, 0);

        // R4 expire
        wait_cnt(6'h01);
        @(negedge clk);
        chk("R4 pulse high", sys_rst_req, 1);
        rd(5'h0C, d); chk("R4 rf set", d[1], 1);
        @(negedge clk);
        chk("R4 pulse low", sys_rst_req, 0);
        rd(5'h10, d); chk("R4 rearm", d, 32'h3F);

        // R10 debug freeze
        dbg_halt = 1'b1;
        repeat (2) @(negedge clk);
        rd(5'h10, d);
        repeat (8) @(negedge clk);
        begin
            logic [31:0] d2;
            rd(5'h10, d2); chk("R10 frozen", d2, d);
            wr(5'h04, ctrl(1, 0, 6'h10, 1));
            repeat (4) @(negedge clk);
            rd(5'h10, d2); chk("R10 runs in debug", d2 < d ? 1 : 0, 1);
        end
        dbg_halt = 1'b0;
        wr(5'h04, 0);

        // R11 flag survives rst_n
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(5'h0C, d); chk("R11 rf survives", d[1], 1);
        rd(5'h04, d); chk("R11 ctrl reset", d, 0);
        flag_por_n = 1'b0;
        @(negedge clk);
        flag_por_n = 1'b1;
        rd(5'h0C, d); chk("R11 por clears", d[1], 0);

        finish_run();
    end
endmodule